// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps a DRAM array model alive. It issues one row-refresh operation at a time, so that every row of the array is refreshed once in each retention window. It holds an interval timer, a window position counter, a count of rows still owed and the address of the next row. It shares the array with ordinary read and write traffic through a request, grant and in-flight handshake. While a row is being refreshed the block raises a memory-unavailable flag, and it grants no access during that time.

Two policies can be chosen at run time. In spread mode one row becomes due at the end of every sub-interval, so the array stalls briefly and evenly across the window. In block mode every row becomes due together at the start of the window and is refreshed back to back, so the array is locked out for one long stretch. The policy input is captured only at the start of a window. A change made partway through a window therefore never skips rows or refreshes them twice. All timing is counted in clock cycles and set by parameters. At a 100 MHz clock the defaults give 8192 rows at 780 cycles each, which fits inside a 6,400,000-cycle window.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and right after reset, `refStb` and `memBusy` are 0, `refRow` is 0, and the sub-interval timer and window position are at 0.
- R2: In spread mode (`modeBurst`=0) one row becomes due each time SUB_CYC cycles have elapsed. The first becomes due after the SUB_CYC-th clock edge following reset release. With no access in flight, `refStb` is high in the cycle after that edge, so the strobes are exactly SUB_CYC cycles apart.
- R3: Each row refresh holds `memBusy` high for exactly ROW_CYC cycles. `refStb` is high only in the first of those cycles, and `refRow` then shows the row being refreshed.
- R4: Rows are refreshed in ascending order. After row ROWS-1 the next row is row 0.
- R5: In block mode, all ROWS rows become due at the first sub-interval expiry of a window and are refreshed back to back. `memBusy` then stays high for ROWS*ROW_CYC consecutive cycles, and no row becomes due at the other expiries of that window.
- R6: A window spans ROWS sub-interval expiries. Expiry number 0, ROWS, 2*ROWS and so on opens a window. `modeBurst` is sampled only at those expiries, and the sampled policy governs the whole window.
- R7: `accGnt` equals `accReq` when no refresh is running and no row is owed. Otherwise it is 0.
- R8: A row that is owed does not start while `accActive` is 1. The requester must hold `accActive` high from the cycle after its grant until its access ends. The refresh starts on the first clock edge that samples `accActive` low.
- R9: A request held high while `memBusy` is 1 is not lost. If no further row is owed, it is granted in the first cycle in which `memBusy` is 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeBurst | input | 1 | Policy select: 0 spread, 1 block; sampled at window start |
| accReq | input | 1 | Read or write access request, held until granted |
| accActive | input | 1 | A granted access is still in flight |
| accGnt | output | 1 | Access granted this cycle |
| refStb | output | 1 | First cycle of a row refresh |
| refRow | output | $clog2(ROWS) | Row being refreshed (next row when idle) |
| memBusy | output | 1 | Array unavailable: a row refresh is in progress |

## Verification
With no traffic in spread mode, the bench checks that strobes fall on exact multiples of the sub-interval and that row addresses wrap. This separates a correct timer and counter from ones that are off by one. The policy is switched in the middle of a window in both directions. The expected sequence of busy-run lengths (short single-row runs against one long run) and the absence of strobes for the rest of a block-mode window show whether the policy is latched at the window start or applied at once. Access requests are timed to overlap a due row and a running refresh. A refresh that starts too early, a grant given while a row is owed, or a held request that is dropped each shows up as a wrong strobe cycle or a wrong grant cycle.

// File: rtl/ref_pkg.sv
package ref_pkg;

  typedef enum logic {
    REF_IDLE = 1'b0,
    REF_ROW  = 1'b1
  } refState_e;

  // Strobes from the control FSM to the row/timer datapath
  typedef struct packed {
    logic rowStart;  // first cycle of a row refresh
    logic rowDone;   // last cycle of a row refresh
  } refCtl_t;

endpackage

// File: rtl/ref_datapath.sv
module ref_datapath
  import ref_pkg::*;
#(
  parameter int ROWS    = 8192,
  parameter int SUB_CYC = 780
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    modeBurst,
  input  refCtl_t                 ctl,
  output logic                    pendAny,
  output logic                    pendMore,
  output logic [$clog2(ROWS)-1:0] refRow
);

  localparam int ROW_W  = $clog2(ROWS);
  localparam int TMR_W  = (SUB_CYC > 1) ? $clog2(SUB_CYC) : 1;
  localparam int PEND_W = $clog2(ROWS + 2);
  localparam logic [ROW_W-1:0]  LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [TMR_W-1:0]  LAST_TMR = TMR_W'(SUB_CYC - 1);
  localparam logic [PEND_W-1:0] ALL_ROWS = PEND_W'(ROWS);

  logic [TMR_W-1:0]  tmr;
  logic [ROW_W-1:0]  win;
  logic [ROW_W-1:0]  rowAddr;
  logic [PEND_W-1:0] pendRows;
  logic [PEND_W-1:0] addRows;
  logic [PEND_W-1:0] pendNext;
  logic              modeLat;
  logic              tick;
  logic              winStart;
  logic              effBurst;

  assign tick     = (tmr == LAST_TMR);
  assign winStart = tick && (win == '0);
  assign effBurst = winStart ? modeBurst : modeLat;

  always_comb begin
    addRows = '0;
    if (tick) begin
      if (!effBurst)     addRows = PEND_W'(1);
      else if (winStart) addRows = ALL_ROWS;
    end
  end

  assign pendNext = pendRows + addRows - {{(PEND_W-1){1'b0}}, ctl.rowDone};
  assign pendAny  = (pendRows != '0);
  assign pendMore = (pendRows > PEND_W'(1)) || (addRows != '0);
  assign refRow   = rowAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr      <= '0;
      win      <= '0;
      pendRows <= '0;
      rowAddr  <= '0;
      modeLat  <= 1'b0;
    end else begin
      tmr      <= tick ? '0 : tmr + 1'b1;
      pendRows <= pendNext;
      if (tick)        win     <= (win == LAST_ROW) ? '0 : win + 1'b1;
      if (ctl.rowDone) rowAddr <= (rowAddr == LAST_ROW) ? '0 : rowAddr + 1'b1;
      if (winStart)    modeLat <= modeBurst;
    end
  end

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !winStart |=> $stable(modeLat));

  // R4
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rowDone && rowAddr == LAST_ROW) |=> (rowAddr == '0));

  // R5
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendRows <= PEND_W'(ROWS + 1));

  // R2
  start_owed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rowStart |-> ($past(pendRows) != '0));

endmodule

// File: rtl/ref_ctrl.sv
module ref_ctrl
  import ref_pkg::*;
#(
  parameter int ROW_CYC = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    accReq,
  input  logic    accActive,
  input  logic    pendAny,
  input  logic    pendMore,
  output refCtl_t ctl,
  output logic    accGnt,
  output logic    refStb,
  output logic    memBusy
);

  localparam int CYC_W = (ROW_CYC > 1) ? $clog2(ROW_CYC) : 1;
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(ROW_CYC - 1);

  refState_e        state;
  logic [CYC_W-1:0] cyc;
  logic             lastCyc;

  assign lastCyc     = (cyc == LAST_CYC);
  assign ctl.rowStart = (state == REF_ROW) && (cyc == '0);
  assign ctl.rowDone  = (state == REF_ROW) && lastCyc;
  assign memBusy     = (state == REF_ROW);
  assign refStb      = ctl.rowStart;
  assign accGnt      = accReq && (state == REF_IDLE) && !pendAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= REF_IDLE;
      cyc   <= '0;
    end else begin
      case (state)
        REF_IDLE: begin
          cyc <= '0;
          if (pendAny && !accActive) state <= REF_ROW;
        end
        REF_ROW: begin
          if (lastCyc) begin
            cyc <= '0;
            if (!pendMore) state <= REF_IDLE;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        default: state <= REF_IDLE;
      endcase
    end
  end

  // R8
  start_idle_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memBusy) |-> !$past(accActive));

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memBusy) |-> ($past(cyc) == LAST_CYC));

  // R7
  gnt_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    accGnt |=> !memBusy);

  // R3
  stb_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    refStb |-> memBusy);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import ref_pkg::*;
#(
  parameter int ROWS    = 8192,
  parameter int SUB_CYC = 780,
  parameter int ROW_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    modeBurst,
  input  logic                    accReq,
  input  logic                    accActive,
  output logic                    accGnt,
  output logic                    refStb,
  output logic [$clog2(ROWS)-1:0] refRow,
  output logic                    memBusy
);

  refCtl_t ctl;
  logic    pendAny;
  logic    pendMore;

  ref_datapath #(.ROWS(ROWS), .SUB_CYC(SUB_CYC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .modeBurst(modeBurst),
    .ctl      (ctl),
    .pendAny  (pendAny),
    .pendMore (pendMore),
    .refRow   (refRow)
  );

  ref_ctrl #(.ROW_CYC(ROW_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accReq   (accReq),
    .accActive(accActive),
    .pendAny  (pendAny),
    .pendMore (pendMore),
    .ctl      (ctl),
    .accGnt   (accGnt),
    .refStb   (refStb),
    .memBusy  (memBusy)
  );

endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;

  localparam int ROWS = 4;
  localparam int SUB  = 20;
  localparam int RC   = 3;
  localparam int ACC  = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeBurst = 1'b0;
  logic       accReq = 1'b0;
  logic       accActive = 1'b0;
  logic       accGnt;
  logic       refStb;
  logic [1:0] refRow;
  logic       memBusy;

  int cyc = 0;
  int accCnt = 0;
  int total = 0;
  int fails = 0;
  int stbIdx = 0;
  int runLen = 0;
  int stbCount = 0;
  int gntBusyErr = 0;
  int stbAccErr = 0;
  bit done = 1'b0;
  int expRow[$];
  int expRun[$];

  dram_refresh_sched #(.ROWS(ROWS), .SUB_CYC(SUB), .ROW_CYC(RC)) u0 (
    .clk(clk), .rstN(rstN), .modeBurst(modeBurst), .accReq(accReq),
    .accActive(accActive), .accGnt(accGnt), .refStb(refStb),
    .refRow(refRow), .memBusy(memBusy)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= rstN ? cyc + 1 : 0;

  // memory model: access stays in flight for ACC cycles after its grant
  always @(posedge clk) begin
    if (!rstN) begin
      accActive <= 1'b0;
      accCnt    <= 0;
    end else if (accGnt) begin
      accActive <= 1'b1;
      accCnt    <= ACC - 1;
    end else if (accCnt != 0) begin
      accCnt <= accCnt - 1;
    end else begin
      accActive <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard as refreshes appear
  always @(negedge clk) begin
    if (rstN) begin
      if (refStb) begin
        stbCount++;
        if (expRow.size() == 0) chk(0, "R4 unexpected row", int'(refRow), -1);
        else begin
          int e;
          e = expRow.pop_front();
          chk(int'(refRow) == e, "R4 row order", int'(refRow), e);
        end
        if (stbIdx < 12)
          chk(cyc == SUB * (stbIdx + 1) + 1, "R2 strobe cycle", cyc, SUB * (stbIdx + 1) + 1);
        stbIdx++;
        if (accActive) stbAccErr++;
      end
      if (accGnt && memBusy) gntBusyErr++;
      if (memBusy) runLen++;
      else if (runLen != 0) begin
        if (expRun.size() == 0) chk(0, "R5 unexpected busy run", runLen, -1);
        else begin
          int e;
          e = expRun.pop_front();
          chk(runLen == e, "R3/R5 busy run length", runLen, e);
        end
        runLen = 0;
      end
    end
  end

  initial begin
    int s0;
    // driver: expected refresh rows and busy run lengths
    for (int i = 0; i < 29; i++) expRow.push_back(i % ROWS);
    for (int i = 0; i < 12; i++) expRun.push_back(RC);
    expRun.push_back(ROWS * RC);
    expRun.push_back(ROWS * RC);
    for (int i = 0; i < 9; i++) expRun.push_back(RC);

    repeat (3) @(negedge clk);
    chk(refStb == 1'b0, "R1 strobe in reset", int'(refStb), 0);
    chk(memBusy == 1'b0, "R1 busy in reset", int'(memBusy), 0);
    chk(refRow == 2'd0, "R1 row in reset", int'(refRow), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(memBusy == 1'b0, "R1 busy after reset", int'(memBusy), 0);
    accReq = 1'b1;
    #1;
    chk(accGnt == 1'b1, "R7 idle grant", int'(accGnt), 1);
    accReq = 1'b0;

    // switch to block mode inside the third window: takes effect at its end (R6)
    waitCyc(205);
    modeBurst = 1'b1;
    waitCyc(273);
    s0 = stbCount;
    waitCyc(339);
    chk(stbCount == s0, "R5 no rows after burst in window", stbCount - s0, 0);
    waitCyc(350);
    modeBurst = 1'b0;
    waitCyc(353);
    s0 = stbCount;
    waitCyc(419);
    chk(stbCount == s0, "R6 policy held until window end", stbCount - s0, 0);

    // access in flight when a row becomes due (R8)
    waitCyc(437);
    accReq = 1'b1;
    #1;
    chk(accGnt == 1'b1, "R7 grant before due row", int'(accGnt), 1);
    @(posedge clk);
    #1 accReq = 1'b0;
    waitCyc(441);
    accReq = 1'b1;
    #1;
    chk(accGnt == 1'b0, "R7 no grant while row owed", int'(accGnt), 0);
    while (!refStb) @(negedge clk);
    chk(cyc == 438 + ACC + 1, "R8 refresh waits for access", cyc, 438 + ACC + 1);
    while (memBusy) @(negedge clk);
    chk(accGnt == 1'b1, "R9 held request granted", int'(accGnt), 1);
    chk(cyc == 444 + RC, "R9 grant cycle", cyc, 444 + RC);
    @(posedge clk);
    #1 accReq = 1'b0;

    // request raised during a refresh (R9)
    waitCyc(482);
    chk(memBusy == 1'b1, "R3 busy mid row", int'(memBusy), 1);
    accReq = 1'b1;
    #1;
    chk(accGnt == 1'b0, "R7 no grant while busy", int'(accGnt), 0);
    while (memBusy) @(negedge clk);
    chk(accGnt == 1'b1, "R9 grant after busy", int'(accGnt), 1);
    chk(cyc == 484, "R9 grant cycle after busy", cyc, 484);
    @(posedge clk);
    #1 accReq = 1'b0;

    waitCyc(600);
    chk(expRow.size() == 0, "R2 all rows refreshed", expRow.size(), 0);
    chk(expRun.size() == 0, "R5 all busy runs seen", expRun.size(), 0);
    chk(gntBusyErr == 0, "R7 grant while busy", gntBusyErr, 0);
    chk(stbAccErr == 0, "R8 strobe during access", stbAccErr, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 600);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule